// File: doc/BRIEF.md
# Synchronous Serial Port Register Front End

This block is the software-visible face of a synchronous serial port controller. It decodes word-aligned reads and writes inside a 4 KB address window. It holds the two configuration registers, an 8-bit clock prescale value and a four-bit interrupt enable mask. The transmit and receive FIFOs and the shift engine live outside this block. Their fill counts come in as inputs, and the block turns those counts into status flags and raw interrupt levels.

A write to the data offset becomes a push strobe towards the transmit FIFO. The pushed data is trimmed to the configured frame size. A read of the data offset returns the word at the head of the receive FIFO and issues a pop strobe. Two sticky interrupt sources, receive overrun and receive timeout, are set by pulses from the transfer engine. Software clears them through a write-one-to-clear register. One level-sensitive interrupt line reports any enabled source. The top of the window returns a fixed set of identification bytes.

Top module: `ssp_regfront`

## Requirements
- R1: After reset the mask is 0 and both sticky bits are clear. With both fill counts at 0, the status word reads 0x03, the raw interrupt word reads 0x8 and `irq` is low.
- R2: The status word at 0x0C has five bits. Bit 0 is set when the transmit count is 0. Bit 1 is set when the transmit count is below 8. Bit 2 is set when the receive count is nonzero. Bit 3 is set when the receive count equals 8. Bit 4 (busy) is set when the transmit count is nonzero.
- R3: Raw interrupt bit 2 is set when the receive count is 4 or more. Raw interrupt bit 3 is set when the transmit count is 4 or less. Both follow the counts directly.
- R4: Raw interrupt bits 0 (overrun) and 1 (timeout) are set by `ovr_pulse` and `tmo_pulse` and stay set. A write to 0x20 clears bit 0 or bit 1 where the written bit is 1, and leaves bits 2 and 3 untouched. If a pulse and a clear of the same bit arrive in one cycle, the bit stays set.
- R5: The mask lives at 0x14, bits 3:0. The masked word at 0x1C returns the raw word AND the mask. `irq` is high exactly when that AND is nonzero.
- R6: A read of 0x08 with a nonzero receive count returns `rx_head_data` and raises `rx_pop` in that cycle. With a receive count of 0 it returns 0 and `rx_pop` stays low.
- R7: A write to 0x08 with a transmit count below 8 raises `tx_push`. `tx_push_data` carries the write data with every bit above position cfg0[3:0] forced to 0. With a transmit count of 8 the write raises no push.
- R8: Configuration 0 at 0x00 keeps 16 bits and configuration 1 at 0x04 keeps 4 bits. Each reads back as written and drives `cfg0` and `cfg1`.
- R9: The prescale register at 0x10 keeps only the low 8 bits of a write. Offset 0x24 always reads 0.
- R10: Word offsets 0xFE0 up to 0xFFC return the bytes 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, in that order.
- R11: A read of any unmapped offset returns 0. A write to one changes no register and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for this cycle |
| rd_en | input | 1 | Read strobe for this cycle |
| addr | input | 12 | Byte offset in the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the same cycle as `rd_en` |
| tx_count | input | 4 | Transmit FIFO fill count |
| rx_count | input | 4 | Receive FIFO fill count |
| rx_head_data | input | 16 | Word at the head of the receive FIFO |
| ovr_pulse | input | 1 | Sets the receive overrun bit |
| tmo_pulse | input | 1 | Sets the receive timeout bit |
| tx_push | output | 1 | Push strobe to the transmit FIFO |
| tx_push_data | output | 16 | Data pushed, trimmed to the frame size |
| rx_pop | output | 1 | Pop strobe to the receive FIFO |
| cfg0 | output | 16 | Configuration 0 contents |
| cfg1 | output | 4 | Configuration 1 contents |
| prescale | output | 8 | Prescale contents |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a FIFO depth of 8, thresholds of 4 and a data width of 16. The fill counts are inputs, so the bench drives them straight to the full and empty extremes and to both sides of each threshold, with no FIFO to fill. That reaches every status and raw interrupt combination, including the full-FIFO push and the empty-FIFO pop. The same-cycle set-and-clear collision on the sticky bits and trimming to several frame sizes are exercised directly.

// File: rtl/ssp_regfront_pkg.sv
package ssp_regfront_pkg;
    localparam int CFG0_W  = 16;
    localparam int CFG1_W  = 4;
    localparam int PRE_W   = 8;
    localparam int INT_W   = 4;
    localparam int STAT_W  = 5;
    localparam int BUS_W   = 32;
    localparam int OFF_W   = 12;

    typedef enum logic [3:0] {
        SEL_CFG0, SEL_CFG1, SEL_DATA, SEL_STAT, SEL_PRE,
        SEL_MASK, SEL_RAW,  SEL_MSK_STAT, SEL_CLR, SEL_DMA,
        SEL_IDENT, SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic [CFG0_W-1:0] cfg0;
        logic [CFG1_W-1:0] cfg1;
        logic [PRE_W-1:0]  presc;
        logic [INT_W-1:0]  imask;
        logic              ovr;
        logic              tmo;
    } regs_t;
endpackage

// File: rtl/ssp_addr_decode.sv
module ssp_addr_decode
    import ssp_regfront_pkg::*;
(
    input  logic [OFF_W-1:0] addr,
    output reg_sel_e         sel,
    output logic [2:0]       ident_idx
);
    localparam int WORD_W = OFF_W - 2;
    logic [WORD_W-1:0] word;

    always_comb begin
        word      = addr[OFF_W-1:2];
        ident_idx = addr[4:2];
        sel       = SEL_NONE;
        if (addr[OFF_W-1:5] == '1) begin
            sel = SEL_IDENT;
        end else begin
            case (word)
                WORD_W'(0): sel = SEL_CFG0;
                WORD_W'(1): sel = SEL_CFG1;
                WORD_W'(2): sel = SEL_DATA;
                WORD_W'(3): sel = SEL_STAT;
                WORD_W'(4): sel = SEL_PRE;
                WORD_W'(5): sel = SEL_MASK;
                WORD_W'(6): sel = SEL_RAW;
                WORD_W'(7): sel = SEL_MSK_STAT;
                WORD_W'(8): sel = SEL_CLR;
                WORD_W'(9): sel = SEL_DMA;
                default:    sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ssp_flag_calc.sv
module ssp_flag_calc
    import ssp_regfront_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int RX_THR = 4,
    parameter int TX_THR = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    output logic [STAT_W-1:0] status,
    output logic              rx_level,
    output logic              tx_level
);
    always_comb begin
        status[0] = (tx_count == '0);
        status[1] = (tx_count != CNT_W'(DEPTH));
        status[2] = (rx_count != '0);
        status[3] = (rx_count == CNT_W'(DEPTH));
        status[4] = (tx_count != '0);
        rx_level  = (rx_count >= CNT_W'(RX_THR));
        tx_level  = (tx_count <= CNT_W'(TX_THR));
    end
endmodule

// File: rtl/ssp_ident_rom.sv
module ssp_ident_rom (
    input  logic [2:0] idx,
    output logic [7:0] byte_out
);
    always_comb begin
        case (idx)
            3'd0:    byte_out = 8'h22;
            3'd1:    byte_out = 8'h10;
            3'd2:    byte_out = 8'h04;
            3'd3:    byte_out = 8'h00;
            3'd4:    byte_out = 8'h0D;
            3'd5:    byte_out = 8'hF0;
            3'd6:    byte_out = 8'h05;
            default: byte_out = 8'hB1;
        endcase
    end
endmodule

// File: rtl/ssp_regfront.sv
module ssp_regfront
    import ssp_regfront_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int RX_THR = 4,
    parameter int TX_THR = 4,
    parameter int DATA_W = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [11:0]       addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [DATA_W-1:0] rx_head_data,
    input  logic              ovr_pulse,
    input  logic              tmo_pulse,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_push_data,
    output logic              rx_pop,
    output logic [15:0]       cfg0,
    output logic [3:0]        cfg1,
    output logic [7:0]        prescale,
    output logic              irq
);
    reg_sel_e          sel;
    logic [2:0]        ident_idx;
    logic [7:0]        ident_byte;
    logic [STAT_W-1:0] status;
    logic              rx_level;
    logic              tx_level;
    logic [INT_W-1:0]  raw;
    logic [INT_W-1:0]  masked;
    logic [DATA_W-1:0] frame_mask;
    regs_t             regs_d, regs_q;

    ssp_addr_decode u_dec (
        .addr      (addr),
        .sel       (sel),
        .ident_idx (ident_idx)
    );

    ssp_flag_calc #(
        .DEPTH  (DEPTH),
        .RX_THR (RX_THR),
        .TX_THR (TX_THR)
    ) u_flags (
        .tx_count (tx_count),
        .rx_count (rx_count),
        .status   (status),
        .rx_level (rx_level),
        .tx_level (tx_level)
    );

    ssp_ident_rom u_ident (
        .idx      (ident_idx),
        .byte_out (ident_byte)
    );

    // Frame-size mask: bits 0..cfg0[3:0] pass.
    for (genvar b = 0; b < DATA_W; b++) begin : g_fmask
        assign frame_mask[b] = (b <= int'(regs_q.cfg0[3:0]));
    end

    always_comb begin
        raw    = {tx_level, rx_level, regs_q.tmo, regs_q.ovr};
        masked = raw & regs_q.imask;
    end

    always_comb begin
        regs_d       = regs_q;
        tx_push      = 1'b0;
        rx_pop       = 1'b0;
        tx_push_data = wdata[DATA_W-1:0] & frame_mask;
        if (wr_en) begin
            case (sel)
                SEL_CFG0: regs_d.cfg0  = wdata[CFG0_W-1:0];
                SEL_CFG1: regs_d.cfg1  = wdata[CFG1_W-1:0];
                SEL_PRE:  regs_d.presc = wdata[PRE_W-1:0];
                SEL_MASK: regs_d.imask = wdata[INT_W-1:0];
                SEL_DATA: tx_push      = (tx_count < CNT_W'(DEPTH));
                SEL_CLR: begin
                    if (wdata[0]) regs_d.ovr = 1'b0;
                    if (wdata[1]) regs_d.tmo = 1'b0;
                end
                default: ;
            endcase
        end
        if (ovr_pulse) regs_d.ovr = 1'b1;
        if (tmo_pulse) regs_d.tmo = 1'b1;

        rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_CFG0:     rdata = BUS_W'(regs_q.cfg0);
                SEL_CFG1:     rdata = BUS_W'(regs_q.cfg1);
                SEL_STAT:     rdata = BUS_W'(status);
                SEL_PRE:      rdata = BUS_W'(regs_q.presc);
                SEL_MASK:     rdata = BUS_W'(regs_q.imask);
                SEL_RAW:      rdata = BUS_W'(raw);
                SEL_MSK_STAT: rdata = BUS_W'(masked);
                SEL_IDENT:    rdata = BUS_W'(ident_byte);
                SEL_DATA: begin
                    if (rx_count != '0) begin
                        rdata  = BUS_W'(rx_head_data);
                        rx_pop = 1'b1;
                    end
                end
                default:      rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cfg0     = regs_q.cfg0;
    assign cfg1     = regs_q.cfg1;
    assign prescale = regs_q.presc;
    assign irq      = |masked;

    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (rx_count != '0)); // R6
    AST_PUSH_NEEDS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> (tx_count < CNT_W'(DEPTH))); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.ovr && !(wr_en && sel == SEL_CLR && wdata[0])) |=> regs_q.ovr); // R4
    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.tmo && !(wr_en && sel == SEL_CLR && wdata[1])) |=> regs_q.tmo); // R4
    AST_NO_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.imask == '0) |-> !irq); // R5
    AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_PRE) |=> $stable(prescale)); // R9
    AST_BUSY_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[0] && status[4])); // R2
endmodule

// File: tb/test_ssp_regfront.sv
module test_ssp_regfront;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  tx_count = '0, rx_count = '0;
    logic [15:0] rx_head_data = '0;
    logic        ovr_pulse = 1'b0, tmo_pulse = 1'b0;
    logic        tx_push, rx_pop, irq;
    logic [15:0] tx_push_data, cfg0;
    logic [3:0]  cfg1;
    logic [7:0]  prescale;

    int checks = 0, errors = 0;
    bit done = 0;
    logic        last_push, last_pop;
    logic [15:0] last_push_data;
    logic        m_ovr = 0, m_tmo = 0;
    logic [3:0]  m_mask = 0;

    always #5 clk = ~clk;

    ssp_regfront i_ssp_regfront (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tx_count(tx_count), .rx_count(rx_count),
        .rx_head_data(rx_head_data), .ovr_pulse(ovr_pulse), .tmo_pulse(tmo_pulse),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .rx_pop(rx_pop),
        .cfg0(cfg0), .cfg1(cfg1), .prescale(prescale), .irq(irq)
    );

    function automatic logic [31:0] exp_status(logic [3:0] t, logic [3:0] r);
        return {27'd0, t != 0, r == 8, r != 0, t != 8, t == 0};
    endfunction

    function automatic logic [31:0] exp_raw(logic [3:0] t, logic [3:0] r, logic o, logic m);
        return {28'd0, t <= 4, r >= 4, m, o};
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d, logic op = 0, logic tp = 0);
        @(negedge clk);
        wr_en = 1; addr = a; wdata = d; ovr_pulse = op; tmo_pulse = tp;
        #1 last_push = tx_push; last_push_data = tx_push_data;
        @(posedge clk);
        #1 wr_en = 0; ovr_pulse = 0; tmo_pulse = 0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1; addr = a;
        #1 d = rdata; last_pop = rx_pop;
        @(posedge clk);
        #1 rd_en = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        rd(12'h00C, v); chk("R1 status", v, 32'h03);
        rd(12'h018, v); chk("R1 raw", v, 32'h8);
        rd(12'h014, v); chk("R1 mask", v, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        // R8 configuration registers
        wr(12'h000, 32'hFFFF_A5C7); rd(12'h000, v); chk("R8 cfg0", v, 32'hA5C7);
        chk("R8 cfg0 port", {16'd0, cfg0}, 32'hA5C7);
        wr(12'h004, 32'hFFFF_FFF9); rd(12'h004, v); chk("R8 cfg1", v, 32'h9);
        chk("R8 cfg1 port", {28'd0, cfg1}, 32'h9);

        // R9 prescale and DMA control
        wr(12'h010, 32'h1234_56AB); rd(12'h010, v); chk("R9 prescale", v, 32'hAB);
        wr(12'h024, 32'hFFFF_FFFF); rd(12'h024, v); chk("R9 dma", v, 32'h0);

        // R10 identification bytes
        for (int k = 0; k < 8; k++) begin
            logic [7:0] idb [8] = '{8'h22, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
            rd(12'hFE0 + 12'(k * 4), v); chk("R10 ident", v, {24'd0, idb[k]});
        end

        // R11 unmapped
        rd(12'h028, v); chk("R11 read", v, 32'h0);
        rd(12'h800, v); chk("R11 read hi", v, 32'h0);
        wr(12'h028, 32'hFFFF_FFFF);
        chk("R11 no push", {31'd0, last_push}, 32'd0);
        rd(12'h000, v); chk("R11 cfg0 kept", v, 32'hA5C7);
        rd(12'h010, v); chk("R11 presc kept", v, 32'hAB);
        rd(12'h014, v); chk("R11 mask kept", v, 32'h0);
        rd(12'h018, v); chk("R11 raw kept", v, 32'h8);

        // R7 push with trimming and full drop
        tx_count = 4'd3;
        wr(12'h000, 32'h0007); wr(12'h008, 32'h0001_ABCD);
        chk("R7 push", {31'd0, last_push}, 32'd1);
        chk("R7 trim8", {16'd0, last_push_data}, 32'h00CD);
        wr(12'h000, 32'h0003); wr(12'h008, 32'h0000_FFFF);
        chk("R7 trim4", {16'd0, last_push_data}, 32'h000F);
        wr(12'h000, 32'h000F); wr(12'h008, 32'h0000_BEEF);
        chk("R7 trim16", {16'd0, last_push_data}, 32'hBEEF);
        tx_count = 4'd8;
        wr(12'h008, 32'h0000_1111);
        chk("R7 full drop", {31'd0, last_push}, 32'd0);
        tx_count = 4'd0;

        // R6 data reads
        rx_count = 4'd0; rx_head_data = 16'h5A5A;
        rd(12'h008, v); chk("R6 empty data", v, 32'h0);
        chk("R6 empty no pop", {31'd0, last_pop}, 32'd0);
        rx_count = 4'd2;
        rd(12'h008, v); chk("R6 data", v, 32'h5A5A);
        chk("R6 pop", {31'd0, last_pop}, 32'd1);
        rx_count = 4'd0;

        // R4 set and clear collision, clear leaves level bits
        wr(12'h020, 32'h1, 1'b1, 1'b0); m_ovr = 1;
        rd(12'h018, v); chk("R4 set wins", v, exp_raw(0, 0, 1, 0));
        wr(12'h020, 32'hF); m_ovr = 0;
        rd(12'h018, v); chk("R4 clear keeps levels", v, exp_raw(0, 0, 0, 0));

        // Random mix: R2 R3 R4 R5
        for (int it = 0; it < 60; it++) begin
            logic op, tp;
            logic [31:0] cv;
            @(negedge clk);
            tx_count = 4'($urandom_range(0, 8));
            rx_count = 4'($urandom_range(0, 8));
            op = ($urandom % 3) == 0;
            tp = ($urandom % 3) == 0;
            if (op || tp) begin
                wr(12'h030, 32'h0, op, tp);
                m_ovr = m_ovr | op; m_tmo = m_tmo | tp;
            end
            case ($urandom % 4)
                0: begin
                    cv = 32'($urandom % 4);
                    wr(12'h020, cv);
                    if (cv[0]) m_ovr = 0;
                    if (cv[1]) m_tmo = 0;
                end
                1: begin
                    m_mask = 4'($urandom);
                    wr(12'h014, {28'd0, m_mask});
                end
                default: ;
            endcase
            rd(12'h00C, v); chk("R2 status", v, exp_status(tx_count, rx_count));
            rd(12'h018, v); chk("R3 R4 raw", v, exp_raw(tx_count, rx_count, m_ovr, m_tmo));
            rd(12'h01C, v);
            chk("R5 masked", v, exp_raw(tx_count, rx_count, m_ovr, m_tmo) & {28'd0, m_mask});
            chk("R5 irq", {31'd0, irq},
                {31'd0, |(exp_raw(tx_count, rx_count, m_ovr, m_tmo) & {28'd0, m_mask})});
        end

        // Directed threshold edges for R3
        tx_count = 4'd5; rx_count = 4'd3;
        rd(12'h018, v); chk("R3 edge low", v, exp_raw(5, 3, m_ovr, m_tmo));
        tx_count = 4'd4; rx_count = 4'd4;
        rd(12'h018, v); chk("R3 edge hit", v, exp_raw(4, 4, m_ovr, m_tmo));

        done = 1;
        finish_run();
    end
endmodule